// File: doc/BRIEF.md
# Single-Lane Stream Block Framer

This block takes a 64-bit byte stream with packet boundaries and turns it into one 66-bit line block per clock. Each block has a 2-bit sync header and eight payload bytes. Mid-packet beats go out unchanged as data blocks. The end of every packet is marked by a separator control block, which carries a byte count and any trailing bytes. Cycles with nothing to send produce idle control blocks. A clock-compensation request outranks traffic: it emits a fixed burst of compensation blocks and holds the input off for the whole burst. Scrambling, gearboxing, striping across lanes and CRC are handled by other blocks downstream.

Payload byte k sits at bits [8k+7:8k] of `blk_payload`, and byte 0 is the first byte on the line. Output blocks are registered. A beat accepted at a clock edge appears at the outputs after that edge.

The controller has three states:
- `ST_RUN`: passes data, separators and idles.
- `ST_SEP_ZERO`: emits the empty separator that follows a completely full last beat.
- `ST_COMP`: emits the remaining compensation blocks.

The transitions are:
- `ST_RUN` to `ST_COMP` on a request, live or remembered.
- `ST_RUN` to `ST_SEP_ZERO` on a full last beat.
- `ST_SEP_ZERO` to `ST_RUN` after one cycle.
- `ST_COMP` to `ST_RUN` once the burst count is used up.

Top module: `fr_block_framer`

## Requirements
- R1: A beat is taken only on a cycle where `s_tvalid` and `s_tready` are both high. A taken beat without `s_tlast` appears on the next cycle as a data block: header 2'b01, with the payload equal to `s_tdata`.
- R2: `s_tkeep` has no effect on beats without `s_tlast`. Such a beat is always sent as a full data block.
- R3: A cycle with no beat taken and no separator or compensation due outputs an idle block. An idle block has header 2'b10, byte 0 = 0x78 and all other bytes zero. This includes gaps inside a packet, and the packet continues when `s_tvalid` returns.
- R4: A last beat with n = 0 to 6 valid bytes becomes one separator block with header 2'b10. Byte 0 is 0x1E, byte 1 is n, bytes 2 to n+1 are data bytes 0 to n-1, and all remaining bytes are zero. Here n is the number of ones in `s_tkeep`, which is packed from bit 0 upward.
- R5: A last beat with exactly 7 valid bytes becomes a separator block with header 2'b10. Byte 0 is 0xE1, and bytes 1 to 7 are data bytes 0 to 6.
- R6: A last beat with `s_tkeep` = 0xFF is sent as a data block. On the next cycle an empty separator follows: header 2'b10, byte 0 = 0x1E, all other bytes zero. `s_tready` is low for exactly that one cycle.
- R7: After a last beat of 0 to 7 bytes, `s_tready` is high again on the next cycle unless a compensation request is live.
- R8: A compensation request seen in `ST_RUN` starts a burst of `CC_LEN` (8) consecutive compensation blocks: header 2'b10, byte 0 = 0x80, all other bytes zero. `s_tready` is low from the request cycle until the last block of the burst is on the outputs.
- R9: A request that arrives in `ST_SEP_ZERO` or `ST_COMP` is remembered. Its burst starts right after the current separator or burst, and the separator is never dropped or reordered.
- R10: During and after reset the outputs show an idle block, `s_tready` is high and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tdata | input | 64 | Stream data, byte 0 in bits 7:0 |
| s_tkeep | input | 8 | Valid-byte mask, examined on the last beat only |
| s_tlast | input | 1 | Last beat of a packet |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Framer can take a beat |
| cc_req | input | 1 | Clock-compensation request |
| blk_hdr | output | 2 | Sync header: 01 data, 10 control |
| blk_payload | output | 64 | Block payload bytes |

## Verification
The hardest case to reach from the ports is a compensation request landing while the empty separator after a full beat is being emitted. The request must be held, and it must come out after the separator rather than in its place. Directed stimulus sends a 0xFF last beat and pulses `cc_req` on the following cycle. It then checks the separator, the eight compensation blocks and the idle that follows, cycle by cycle. A second directed case holds a valid beat through a whole burst to show it is stalled and then taken. Random packets with random pauses and requests are compared against an ordered queue of expected non-idle blocks.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    localparam logic [7:0] TYPE_SEP  = 8'h1E;
    localparam logic [7:0] TYPE_SEP7 = 8'hE1;
    localparam logic [7:0] TYPE_IDLE = 8'h78;
    localparam logic [7:0] TYPE_COMP = 8'h80;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SEP_ZERO,
        ST_COMP
    } fr_state_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_DATA,
        BK_SEP,
        BK_SEP7,
        BK_SEP_EMPTY,
        BK_COMP
    } fr_kind_e;

endpackage

// File: rtl/fr_keep_count.sv
module fr_keep_count #(
    parameter int NB = 8,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic [NB-1:0] keep,
    output logic [CW-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < NB; i++) begin
            count = count + CW'(keep[i]);
        end
    end

endmodule

// File: rtl/fr_block_build.sv
module fr_block_build
    import fr_pkg::*;
#(
    parameter int NB = 8,
    localparam int DW = NB * 8,
    localparam int CW = $clog2(NB + 1)
) (
    input  fr_kind_e        kind,
    input  logic [DW-1:0]   data,
    input  logic [CW-1:0]   count,
    output logic [1:0]      hdr,
    output logic [DW-1:0]   payload
);

    logic [DW-1:0] sep_pay;
    logic [DW-1:0] sep7_pay;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] sep_b;
        logic [7:0] sep7_b;
        if (i == 0) begin : g_type
            assign sep_b  = TYPE_SEP;
            assign sep7_b = TYPE_SEP7;
        end else if (i == 1) begin : g_cnt
            assign sep_b  = {{(8-CW){1'b0}}, count};
            assign sep7_b = data[7:0];
        end else begin : g_body
            assign sep_b  = (CW'(i - 2) < count) ? data[8*(i-2) +: 8] : 8'h00;
            assign sep7_b = data[8*(i-1) +: 8];
        end
        assign sep_pay[8*i +: 8]  = sep_b;
        assign sep7_pay[8*i +: 8] = sep7_b;
    end

    always_comb begin
        hdr     = HDR_CTRL;
        payload = DW'(TYPE_IDLE);
        unique case (kind)
            BK_IDLE: begin
                hdr     = HDR_CTRL;
                payload = DW'(TYPE_IDLE);
            end
            BK_DATA: begin
                hdr     = HDR_DATA;
                payload = data;
            end
            BK_SEP: begin
                hdr     = HDR_CTRL;
                payload = sep_pay;
            end
            BK_SEP7: begin
                hdr     = HDR_CTRL;
                payload = sep7_pay;
            end
            BK_SEP_EMPTY: begin
                hdr     = HDR_CTRL;
                payload = DW'(TYPE_SEP);
            end
            BK_COMP: begin
                hdr     = HDR_CTRL;
                payload = DW'(TYPE_COMP);
            end
            default: begin
                hdr     = HDR_CTRL;
                payload = DW'(TYPE_IDLE);
            end
        endcase
    end

endmodule

// File: rtl/fr_ctrl.sv
module fr_ctrl
    import fr_pkg::*;
#(
    parameter int CC_LEN = 8,
    localparam int LW = $clog2(CC_LEN + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_last,
    input  logic     keep_full,
    input  logic     keep_seven,
    input  logic     cc_req,
    output logic     in_ready,
    output fr_kind_e kind
);

    fr_state_e     state, state_nxt;
    logic [LW-1:0] left, left_nxt;
    logic          pend, pend_nxt;
    logic          cc_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            left  <= '0;
            pend  <= 1'b0;
        end else begin
            state <= state_nxt;
            left  <= left_nxt;
            pend  <= pend_nxt;
        end
    end

    always_comb begin
        cc_go     = cc_req | pend;
        in_ready  = 1'b0;
        kind      = BK_IDLE;
        state_nxt = state;
        left_nxt  = left;
        pend_nxt  = pend | cc_req;
        unique case (state)
            ST_RUN: begin
                pend_nxt = 1'b0;
                if (cc_go) begin
                    kind      = BK_COMP;
                    left_nxt  = LW'(CC_LEN - 1);
                    state_nxt = (CC_LEN > 1) ? ST_COMP : ST_RUN;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        if (!in_last) begin
                            kind = BK_DATA;
                        end else if (keep_full) begin
                            kind      = BK_DATA;
                            state_nxt = ST_SEP_ZERO;
                        end else if (keep_seven) begin
                            kind = BK_SEP7;
                        end else begin
                            kind = BK_SEP;
                        end
                    end
                end
            end
            ST_SEP_ZERO: begin
                kind      = BK_SEP_EMPTY;
                state_nxt = ST_RUN;
            end
            ST_COMP: begin
                kind     = BK_COMP;
                left_nxt = left - 1'b1;
                if (left == LW'(1)) begin
                    state_nxt = ST_RUN;
                end
            end
            default: begin
                state_nxt = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/fr_block_framer.sv
module fr_block_framer
    import fr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CC_LEN = 8,
    localparam int NB = DATA_W / 8,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [NB-1:0]     s_tkeep,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              cc_req,
    output logic [1:0]        blk_hdr,
    output logic [DATA_W-1:0] blk_payload
);

    logic [CW-1:0]     keep_cnt;
    fr_kind_e          kind;
    logic [1:0]        hdr_c;
    logic [DATA_W-1:0] pay_c;

    fr_keep_count #(.NB(NB)) i_count (
        .keep  (s_tkeep),
        .count (keep_cnt)
    );

    fr_ctrl #(.CC_LEN(CC_LEN)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s_tvalid),
        .in_last    (s_tlast),
        .keep_full  (keep_cnt == CW'(NB)),
        .keep_seven (keep_cnt == CW'(NB - 1)),
        .cc_req     (cc_req),
        .in_ready   (s_tready),
        .kind       (kind)
    );

    fr_block_build #(.NB(NB)) i_build (
        .kind    (kind),
        .data    (s_tdata),
        .count   (keep_cnt),
        .hdr     (hdr_c),
        .payload (pay_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_hdr     <= HDR_CTRL;
            blk_payload <= DATA_W'(TYPE_IDLE);
        end else begin
            blk_hdr     <= hdr_c;
            blk_payload <= pay_c;
        end
    end

endmodule

// File: rtl/fr_block_framer_chk.sv
module fr_block_framer_chk #(
    parameter int DATA_W = 64,
    parameter int CC_LEN = 8,
    localparam int NB = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] s_tdata,
    input logic [NB-1:0]     s_tkeep,
    input logic              s_tlast,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              cc_req,
    input logic [1:0]        blk_hdr,
    input logic [DATA_W-1:0] blk_payload
);

    logic        fire;
    logic        full_fire;
    logic        cur_cc;
    logic [1:0]  since_rst;
    logic [15:0] cc_run;

    assign fire      = s_tvalid && s_tready;
    assign full_fire = fire && s_tlast && (s_tkeep == {NB{1'b1}}) && (since_rst == 2'd3);
    assign cur_cc    = (blk_hdr == 2'b10) && (blk_payload == DATA_W'(8'h80));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            cc_run    <= '0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
            cc_run <= cur_cc ? cc_run + 1'b1 : 16'd0;
        end
    end

    p_hdr_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_hdr == 2'b01) || (blk_hdr == 2'b10));

    p_data_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !s_tlast) |=> (blk_hdr == 2'b01 && blk_payload == $past(s_tdata)));

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_fire |=> (blk_hdr == 2'b01 && !s_tready));

    p_empty_sep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full_fire, 2) |-> (blk_hdr == 2'b10 && blk_payload == DATA_W'(8'h1E)));

    p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && s_tlast && s_tkeep != {NB{1'b1}}) |=> (s_tready || cc_req));

    p_sep_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_hdr == 2'b10 && blk_payload[7:0] == 8'h1E) |-> (blk_payload[15:8] <= 8'(NB - 2)));

    p_cc_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_cc && cc_run != 16'd0) |-> ((cc_run % CC_LEN) == 0));

endmodule

bind fr_block_framer fr_block_framer_chk #(.DATA_W(DATA_W), .CC_LEN(CC_LEN)) i_chk (.*);

// File: tb/test_fr_block_framer.sv
module test_fr_block_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        cc_req = 1'b0;
    logic [1:0]  blk_hdr;
    logic [63:0] blk_payload;

    always #2.5 clk = ~clk;

    fr_block_framer i_fr_block_framer (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .cc_req(cc_req), .blk_hdr(blk_hdr), .blk_payload(blk_payload)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [65:0] got_q[$];
    logic [65:0] exp_q[$];
    bit mon_en = 1'b0;

    // stimulus table: last-beat mask and its valid byte count
    localparam logic [11:0] VEC [9] = '{
        {8'h00, 4'd0}, {8'h01, 4'd1}, {8'h03, 4'd2}, {8'h07, 4'd3}, {8'h0F, 4'd4},
        {8'h1F, 4'd5}, {8'h3F, 4'd6}, {8'h7F, 4'd7}, {8'hFF, 4'd8}
    };

    function automatic logic [65:0] f_data(logic [63:0] d);
        return {2'b01, d};
    endfunction
    function automatic logic [65:0] f_idle();
        return {2'b10, 64'h78};
    endfunction
    function automatic logic [65:0] f_cc();
        return {2'b10, 64'h80};
    endfunction
    function automatic logic [65:0] f_sep(logic [63:0] d, int n);
        logic [63:0] p;
        logic [63:0] m;
        if (n == 7) begin
            p = {d[55:0], 8'hE1};
        end else begin
            m = (n == 0) ? 64'h0 : (64'hFFFF_FFFF_FFFF_FFFF >> (64 - 8 * n));
            p = ((d & m) << 16) | (64'(n) << 8) | 64'h1E;
        end
        return {2'b10, p};
    endfunction

    always @(negedge clk) begin
        if (mon_en && rst_n && ({blk_hdr, blk_payload} != f_idle()))
            got_q.push_back({blk_hdr, blk_payload});
    end

    task automatic check(bit ok, string req, logic [65:0] act, logic [65:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_beat(logic [63:0] d, int n, bit last);
        if (!last) exp_q.push_back(f_data(d));
        else if (n == 8) begin
            exp_q.push_back(f_data(d));
            exp_q.push_back(f_sep(64'h0, 0));
        end else exp_q.push_back(f_sep(d, n));
    endtask

    task automatic send(logic [63:0] d, logic [7:0] k, bit last, int n);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tkeep = k; s_tlast = last;
        forever begin
            #1;
            if (s_tready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        push_beat(d, n, last);
    endtask

    task automatic drop();
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic cc_pulse();
        @(negedge clk);
        s_tvalid = 1'b0; cc_req = 1'b1;
        @(negedge clk);
        cc_req = 1'b0;
        for (int i = 0; i < 8; i++) exp_q.push_back(f_cc());
    endtask

    task automatic drain(string req);
        drop();
        repeat (24) @(negedge clk);
        check(got_q.size() == exp_q.size(), {req, " block count"},
              66'(got_q.size()), 66'(exp_q.size()));
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            check(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        int ncc;
        int rdy_low;

        // R10: reset state
        repeat (3) @(negedge clk);
        check({blk_hdr, blk_payload} === f_idle(), "R10 idle in reset", {blk_hdr, blk_payload}, f_idle());
        rst_n = 1'b1;
        @(negedge clk);
        check({blk_hdr, blk_payload} === f_idle(), "R10 idle after reset", {blk_hdr, blk_payload}, f_idle());
        check(s_tready === 1'b1, "R10 ready after reset", 66'(s_tready), 66'd1);

        // table walk: one full beat, then a last beat from the table (R4 R5 R6)
        mon_en = 1'b1;
        for (int v = 0; v < 9; v++) begin
            send(rnd64(), 8'h00, 1'b0, 8);
            send(rnd64(), VEC[v][11:4], 1'b1, int'(VEC[v][3:0]));
        end
        drain("R4/R5/R6 table");
        mon_en = 1'b0;

        // R2: mask ignored on a beat without last
        a = rnd64();
        send(a, 8'h01, 1'b0, 8);
        @(negedge clk);
        s_tvalid = 1'b0;
        check({blk_hdr, blk_payload} === f_data(a), "R2 mask ignored", {blk_hdr, blk_payload}, f_data(a));

        // R3: gap in a packet gives idles, then the packet resumes
        a = rnd64();
        send(a, 8'h00, 1'b0, 8);
        @(negedge clk);
        s_tvalid = 1'b0;
        check({blk_hdr, blk_payload} === f_data(a), "R1 data block", {blk_hdr, blk_payload}, f_data(a));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check({blk_hdr, blk_payload} === f_idle(), "R3 idle in gap", {blk_hdr, blk_payload}, f_idle());
        end
        b = rnd64();
        send(b, 8'h0F, 1'b1, 4);
        @(negedge clk);
        s_tvalid = 1'b0;
        check({blk_hdr, blk_payload} === f_sep(b, 4), "R4 resume sep", {blk_hdr, blk_payload}, f_sep(b, 4));
        #1;
        check(s_tready === 1'b1, "R7 ready after partial last", 66'(s_tready), 66'd1);

        // R6: full last beat, empty separator, one cycle not ready
        a = rnd64();
        send(a, 8'hFF, 1'b1, 8);
        @(negedge clk);
        s_tvalid = 1'b0;
        check({blk_hdr, blk_payload} === f_data(a), "R6 full last data", {blk_hdr, blk_payload}, f_data(a));
        #1;
        check(s_tready === 1'b0, "R6 ready low", 66'(s_tready), 66'd0);
        @(negedge clk);
        check({blk_hdr, blk_payload} === f_sep(64'h0, 0), "R6 empty sep", {blk_hdr, blk_payload}, f_sep(64'h0, 0));
        #1;
        check(s_tready === 1'b1, "R6 ready back", 66'(s_tready), 66'd1);
        exp_q.delete();

        // R8: burst stalls a waiting beat
        @(negedge clk);
        b = rnd64();
        cc_req = 1'b1; s_tvalid = 1'b1; s_tdata = b; s_tkeep = 8'h00; s_tlast = 1'b0;
        #1;
        check(s_tready === 1'b0, "R8 ready low on request", 66'(s_tready), 66'd0);
        ncc = 0;
        rdy_low = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            cc_req = 1'b0;
            if ({blk_hdr, blk_payload} === f_cc()) ncc++;
            #1;
            if (!s_tready) rdy_low++;
        end
        check(ncc == 8, "R8 burst length", 66'(ncc), 66'd8);
        check(rdy_low == 7, "R8 ready low through burst", 66'(rdy_low), 66'd7);
        @(negedge clk);
        s_tvalid = 1'b0;
        check({blk_hdr, blk_payload} === f_data(b), "R8 stalled beat taken", {blk_hdr, blk_payload}, f_data(b));

        // R9: request during the empty separator is held
        a = rnd64();
        send(a, 8'hFF, 1'b1, 8);
        @(negedge clk);
        s_tvalid = 1'b0; cc_req = 1'b1;
        @(negedge clk);
        cc_req = 1'b0;
        check({blk_hdr, blk_payload} === f_sep(64'h0, 0), "R9 sep first", {blk_hdr, blk_payload}, f_sep(64'h0, 0));
        ncc = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if ({blk_hdr, blk_payload} === f_cc()) ncc++;
        end
        check(ncc == 8, "R9 held burst", 66'(ncc), 66'd8);
        @(negedge clk);
        check({blk_hdr, blk_payload} === f_idle(), "R9 idle after burst", {blk_hdr, blk_payload}, f_idle());
        exp_q.delete();

        // random packets, pauses and requests against the queue model (R1 R3 R4 R5 R6 R9)
        mon_en = 1'b1;
        for (int f = 0; f < 60; f++) begin
            int len;
            int n;
            len = 1 + int'($urandom_range(0, 4));
            for (int j = 0; j < len - 1; j++) begin
                send(rnd64(), 8'($urandom()), 1'b0, 8);
                if ($urandom_range(0, 3) == 0) begin
                    drop();
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                end
            end
            n = int'($urandom_range(0, 8));
            send(rnd64(), 8'((9'h1 << n) - 1), 1'b1, n);
            if ($urandom_range(0, 4) == 0) cc_pulse();
        end
        drain("R1/R9 random");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule